// File: doc/BRIEF.md
# Dual-Channel Parallel Port Adapter

This block connects a byte-wide processor bus to two identical peripheral channels, A and B. Each channel has an 8-bit port. A direction register sets each pin of the port to input or output on its own. Each channel also has two peripheral control lines. Line 1 is an input that can only raise an interrupt. Line 2 either raises an interrupt as an input or acts as an output: a static level, a one-clock strobe, or a handshake.

The processor reaches four addresses through a 2-bit select, qualified by three chip selects and an access strobe. A per-channel control register chooses the edge polarity and the interrupt masks, and sets the line-2 mode. It also decides whether the data address reaches the output register or the direction register. Each line edge latches a flag even while its interrupt is masked, so software can poll it. Reading the port data clears both of that channel's flags.

The bus read path is registered. A separate output-enable marks the cycle in which the data bus would be driven. Each channel has its own active-low interrupt request.

Top module: `dual_port_adapter`

## Requirements
- R1: After reset every port pin is an input (`pa_dir_o`/`pb_dir_o` = 0), both control registers read 0, both interrupt outputs are high and both line-2 output enables are low.
- R2: The select code maps as follows: 00 = channel A data/direction, 01 = control A, 10 = channel B data/direction, 11 = control B. At a data address, control bit 2 = 1 reaches the output register and bit 2 = 0 reaches the direction register. The two channels are independent.
- R3: An access takes effect only when `en_i` is high and all three `cs_i` bits are 1. Otherwise a write changes nothing and a read leaves `rdata_oe_o` low.
- R4: A direction bit of 1 makes that pin an output. `p*_o` carries the output register. A data read returns the synchronised pin value for each input bit and the output register value for each output bit.
- R5: The line-1 flag (control bit 7) sets on the edge chosen by control bit 1 (0 = falling, 1 = rising). It sets whatever the value of bit 0. Lines and pins pass through two synchronising flops before use.
- R6: With control bit 5 = 0, line 2 is an input. Its flag is control bit 6, bit 4 picks its edge (0 = falling, 1 = rising), and the flag sets whatever the value of bit 3.
- R7: The interrupt output of a channel is low exactly when (bit7 AND bit0) OR (bit6 AND bit3 AND NOT bit5) held in that channel on the previous clock. Otherwise it is high.
- R8: A data read (control bit 2 = 1) clears both flags of its channel, and writes never change control bits 7..6. If an active edge coincides with the clearing read, the flag ends up set.
- R9: With control bits 5..4 = 11, line 2 is an output that follows bit 3, and its output enable is high whenever bit 5 = 1.
- R10: With control bits 5..3 = 101, line 2 goes low for exactly one clock after a data read and is high otherwise.
- R11: With control bits 5..3 = 100, line 2 goes low after a data read and stays low until the next active line-1 edge.
- R12: Read data appears on `rdata_o`, with `rdata_oe_o` high, for the one cycle after the accepted read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Bus access strobe, one cycle per access |
| cs_i | input | 3 | Chip selects; all must be 1 |
| sel_i | input | 2 | Register select |
| rd_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rdata_oe_o | output | 1 | Read data bus drive enable |
| irq_a_n_o | output | 1 | Channel A interrupt, active low |
| irq_b_n_o | output | 1 | Channel B interrupt, active low |
| pa_i | input | 8 | Channel A pin inputs |
| pa_o | output | 8 | Channel A pin output values |
| pa_dir_o | output | 8 | Channel A pin directions (1 = output) |
| a_ln1_i | input | 1 | Channel A line 1 |
| a_ln2_i | input | 1 | Channel A line 2 input |
| a_ln2_o | output | 1 | Channel A line 2 output |
| a_ln2_oe_o | output | 1 | Channel A line 2 output enable |
| pb_i | input | 8 | Channel B pin inputs |
| pb_o | output | 8 | Channel B pin output values |
| pb_dir_o | output | 8 | Channel B pin directions (1 = output) |
| b_ln1_i | input | 1 | Channel B line 1 |
| b_ln2_i | input | 1 | Channel B line 2 input |
| b_ln2_o | output | 1 | Channel B line 2 output |
| b_ln2_oe_o | output | 1 | Channel B line 2 output enable |

## Verification
Two events can fall in the same clock: the flag-clearing data read and a synchronised active edge on line 1. The bench produces this by changing the line on one falling clock edge. It then issues the data read two falling edges later, so that the read is captured on the very clock at which the edge detector fires. The check is a control read that follows: bit 7 must still be set. A design in which the clear wins over the set loses that event and is reported.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int DW = 8;
  localparam int CTRL_W = 6;
  // control bit positions
  localparam int C_L1_IE   = 0;
  localparam int C_L1_RISE = 1;
  localparam int C_DSEL    = 2;
  localparam int C_L2_B3   = 3;
  localparam int C_L2_B4   = 4;
  localparam int C_L2_OUT  = 5;

  typedef enum logic [1:0] {
    L2_INPUT  = 2'd0,
    L2_LEVEL  = 2'd1,
    L2_PULSE  = 2'd2,
    L2_HSHAKE = 2'd3
  } l2_mode_e;

  function automatic l2_mode_e l2_mode(input logic [CTRL_W-1:0] c);
    if (!c[C_L2_OUT])    return L2_INPUT;
    else if (c[C_L2_B4]) return L2_LEVEL;
    else if (c[C_L2_B3]) return L2_PULSE;
    else                 return L2_HSHAKE;
  endfunction
endpackage

// File: rtl/dpa_sync.sv
module dpa_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/dpa_channel.sv
module dpa_channel
  import dpa_pkg::*;
#(
  parameter int W = DW,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         acc_i,
  input  logic         rd_i,
  input  logic         ctl_sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] pins_o,
  output logic [W-1:0] dir_o,
  input  logic         ln1_i,
  input  logic         ln2_i,
  output logic         ln2_o,
  output logic         ln2_oe_o,
  output logic         irq_n_o
);
  logic [W-1:0]        pin_s;
  logic [1:0]          ln_s, ln_prev;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                f1_q, f2_q, ln2_q, irq_n_q;
  logic [W-1:0]        out_q, dir_q;
  logic                wr, rdacc, data_rd, edge1, edge2;
  l2_mode_e            mode;

  dpa_sync #(.W(W), .STAGES(SYNC)) u_pin_sync (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(pin_s));
  dpa_sync #(.W(2), .STAGES(SYNC)) u_ln_sync (
    .clk(clk), .rst(rst), .d_i({ln2_i, ln1_i}), .q_o(ln_s));

  always_ff @(posedge clk) begin
    if (rst) ln_prev <= '0;
    else     ln_prev <= ln_s;
  end

  assign mode    = l2_mode(ctrl_q);
  assign wr      = acc_i & ~rd_i;
  assign rdacc   = acc_i & rd_i;
  assign data_rd = rdacc & ~ctl_sel_i & ctrl_q[C_DSEL];
  assign edge1   = ctrl_q[C_L1_RISE] ? (ln_s[0] & ~ln_prev[0]) : (~ln_s[0] & ln_prev[0]);
  assign edge2   = ctrl_q[C_L2_B4]   ? (ln_s[1] & ~ln_prev[1]) : (~ln_s[1] & ln_prev[1]);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      out_q  <= '0;
      dir_q  <= '0;
    end else if (wr) begin
      if (ctl_sel_i)           ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (ctrl_q[C_DSEL]) out_q  <= wdata_i;
      else                     dir_q  <= wdata_i;
    end
  end

  // flags: an edge set wins over a read clear
  always_ff @(posedge clk) begin
    if (rst) begin
      f1_q <= 1'b0;
      f2_q <= 1'b0;
    end else begin
      if (edge1)        f1_q <= 1'b1;
      else if (data_rd) f1_q <= 1'b0;
      if (edge2 && mode == L2_INPUT) f2_q <= 1'b1;
      else if (data_rd)              f2_q <= 1'b0;
    end
  end

  // line 2 output
  always_ff @(posedge clk) begin
    if (rst) begin
      ln2_q <= 1'b1;
    end else begin
      unique case (mode)
        L2_INPUT:  ln2_q <= 1'b1;
        L2_LEVEL:  ln2_q <= ctrl_q[C_L2_B3];
        L2_PULSE:  ln2_q <= ~data_rd;
        L2_HSHAKE: begin
          if (data_rd)    ln2_q <= 1'b0;
          else if (edge1) ln2_q <= 1'b1;
        end
        default:   ln2_q <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~((f1_q & ctrl_q[C_L1_IE]) |
                          (f2_q & ctrl_q[C_L2_B3] & ~ctrl_q[C_L2_OUT]));
  end

  always_comb begin
    if (ctl_sel_i)           rdata_o = {f1_q, f2_q, ctrl_q};
    else if (ctrl_q[C_DSEL]) rdata_o = (pin_s & ~dir_q) | (out_q & dir_q);
    else                     rdata_o = dir_q;
  end

  assign pins_o   = out_q;
  assign dir_o    = dir_q;
  assign ln2_o    = ln2_q;
  assign ln2_oe_o = ctrl_q[C_L2_OUT];
  assign irq_n_o  = irq_n_q;

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[C_L1_IE] && !(ctrl_q[C_L2_B3] && !ctrl_q[C_L2_OUT])) |=> irq_n_o);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !edge1) |=> !f1_q);
  assert_flags_ro_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && ctl_sel_i && !edge1) |=> $stable(f1_q));
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (rst)
    edge1 |=> f1_q);
  assert_pulse_one_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == L2_PULSE && !ln2_q && !data_rd && !wr) |=> ln2_q);
  assert_hshake_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mode == L2_HSHAKE && !ln2_q && !edge1 && !wr) |=> !ln2_q);
endmodule

// File: rtl/dual_port_adapter.sv
module dual_port_adapter
  import dpa_pkg::*;
#(
  parameter int CS_N = 3,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic [CS_N-1:0] cs_i,
  input  logic [1:0]      sel_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            rdata_oe_o,
  output logic            irq_a_n_o,
  output logic            irq_b_n_o,
  input  logic [DW-1:0]   pa_i,
  output logic [DW-1:0]   pa_o,
  output logic [DW-1:0]   pa_dir_o,
  input  logic            a_ln1_i,
  input  logic            a_ln2_i,
  output logic            a_ln2_o,
  output logic            a_ln2_oe_o,
  input  logic [DW-1:0]   pb_i,
  output logic [DW-1:0]   pb_o,
  output logic [DW-1:0]   pb_dir_o,
  input  logic            b_ln1_i,
  input  logic            b_ln2_i,
  output logic            b_ln2_o,
  output logic            b_ln2_oe_o
);
  localparam int NCH = 2;

  logic                    sel_ok;
  logic [NCH-1:0]          acc;
  logic [NCH-1:0][DW-1:0]  ch_rdata, ch_pin_i, ch_pin_o, ch_dir;
  logic [NCH-1:0]          ch_l1, ch_l2_i, ch_l2_o, ch_l2_oe, ch_irq_n;
  logic [DW-1:0]           rdata_q;
  logic                    oe_q;

  assign sel_ok   = en_i & (&cs_i);
  assign ch_pin_i = {pb_i, pa_i};
  assign ch_l1    = {b_ln1_i, a_ln1_i};
  assign ch_l2_i  = {b_ln2_i, a_ln2_i};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign acc[g] = sel_ok & (sel_i[1] == g[0]);
      dpa_channel #(.W(DW), .SYNC(SYNC)) u_ch (
        .clk(clk), .rst(rst), .acc_i(acc[g]), .rd_i(rd_i),
        .ctl_sel_i(sel_i[0]), .wdata_i(wdata_i), .rdata_o(ch_rdata[g]),
        .pins_i(ch_pin_i[g]), .pins_o(ch_pin_o[g]), .dir_o(ch_dir[g]),
        .ln1_i(ch_l1[g]), .ln2_i(ch_l2_i[g]), .ln2_o(ch_l2_o[g]),
        .ln2_oe_o(ch_l2_oe[g]), .irq_n_o(ch_irq_n[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= sel_ok & rd_i;
      if (sel_ok && rd_i) rdata_q <= ch_rdata[sel_i[1]];
    end
  end

  assign rdata_o    = rdata_q;
  assign rdata_oe_o = oe_q;
  assign irq_a_n_o  = ch_irq_n[0];
  assign irq_b_n_o  = ch_irq_n[1];
  assign pa_o       = ch_pin_o[0];
  assign pb_o       = ch_pin_o[1];
  assign pa_dir_o   = ch_dir[0];
  assign pb_dir_o   = ch_dir[1];
  assign a_ln2_o    = ch_l2_o[0];
  assign b_ln2_o    = ch_l2_o[1];
  assign a_ln2_oe_o = ch_l2_oe[0];
  assign b_ln2_oe_o = ch_l2_oe[1];

  assert_oe_selected_R3: assert property (@(posedge clk) disable iff (rst)
    rdata_oe_o |-> $past(en_i && rd_i && (&cs_i)));
  assert_oe_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    (!en_i) |=> !rdata_oe_o);
  assert_single_access_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc));
endmodule

// File: tb/dual_port_adapter_tb.sv
module dual_port_adapter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, rd = 1'b0;
  logic [2:0] cs = 3'b000;
  logic [1:0] sel = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_o, pa_dir, pb_o, pb_dir;
  logic       oe, irq_a_n, irq_b_n, a_l2_o, a_l2_oe, b_l2_o, b_l2_oe;
  logic [7:0] pa_i = 8'h00, pb_i = 8'h00;
  logic       a_l1 = 1'b1, a_l2 = 1'b1, b_l1 = 1'b1, b_l2 = 1'b1;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  dual_port_adapter u_dut (
    .clk(clk), .rst(rst), .en_i(en), .cs_i(cs), .sel_i(sel), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe),
    .irq_a_n_o(irq_a_n), .irq_b_n_o(irq_b_n),
    .pa_i(pa_i), .pa_o(pa_o), .pa_dir_o(pa_dir),
    .a_ln1_i(a_l1), .a_ln2_i(a_l2), .a_ln2_o(a_l2_o), .a_ln2_oe_o(a_l2_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_dir_o(pb_dir),
    .b_ln1_i(b_l1), .b_ln2_i(b_l2), .b_ln2_o(b_l2_o), .b_ln2_oe_o(b_l2_oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the bus is driven
  always @(negedge clk) begin
    if (!rst && oe) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 actual %h expected no bus drive", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  // driver: called at a falling edge, returns at the next one
  task automatic access(input logic [1:0] s, input logic r, input logic [7:0] d,
                        input logic [2:0] c, input logic [7:0] e, input string tag);
    en = 1'b1; sel = s; rd = r; wdata = d; cs = c;
    if (r && c == 3'b111) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    en = 1'b0; rd = 1'b0; cs = 3'b000;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    access(s, 1'b0, d, 3'b111, 8'h00, "");
  endtask

  task automatic rdx(input logic [1:0] s, input logic [7:0] e, input string tag);
    access(s, 1'b1, 8'h00, 3'b111, e, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(4);
    // R1 reset state
    chk("R1 dirA", pa_dir, 8'h00);
    chk("R1 dirB", pb_dir, 8'h00);
    chk("R1 irq", {6'd0, irq_a_n, irq_b_n}, 8'h03);
    chk("R1 l2oe", {6'd0, a_l2_oe, b_l2_oe}, 8'h00);
    rdx(2'b01, 8'h00, "R1 ctrlA");
    rdx(2'b11, 8'h00, "R1 ctrlB");
    // R2/R4 map and mixing
    wr(2'b00, 8'h0F);
    wr(2'b01, 8'h04);
    wr(2'b00, 8'hA5);
    idle(1);
    chk("R4 pa_o", pa_o, 8'hA5);
    chk("R2 dirA", pa_dir, 8'h0F);
    pa_i = 8'h3C;
    idle(4);
    rdx(2'b00, 8'h35, "R4 mixed read");
    wr(2'b10, 8'hFF);
    wr(2'b11, 8'h04);
    wr(2'b10, 8'h5A);
    pb_i = 8'h00;
    idle(4);
    rdx(2'b10, 8'h5A, "R4 B outputs");
    rdx(2'b01, 8'h04, "R2 ctrlA independent");
    wr(2'b11, 8'h00);
    rdx(2'b10, 8'hFF, "R2 dirB via bit2=0");
    wr(2'b11, 8'h04);
    // R3 chip select
    access(2'b01, 1'b0, 8'h3F, 3'b011, 8'h00, "");
    access(2'b01, 1'b1, 8'h00, 3'b110, 8'h00, "");
    idle(1);
    chk("R3 no drive", {7'd0, oe}, 8'h00);
    rdx(2'b01, 8'h04, "R3 write ignored");
    // R5 masked flag, falling edge
    a_l1 = 1'b0;
    idle(5);
    chk("R7 masked irqA", {7'd0, irq_a_n}, 8'h01);
    rdx(2'b01, 8'h84, "R5 flag masked");
    rdx(2'b00, 8'h35, "R8 data read");
    rdx(2'b01, 8'h04, "R8 flags cleared");
    a_l1 = 1'b1;
    idle(5);
    rdx(2'b01, 8'h04, "R5 rising ignored");
    // R8 read-only bits
    wr(2'b01, 8'hC4);
    rdx(2'b01, 8'h04, "R8 bits7..6 read-only");
    // R5/R7 rising edge with enable
    wr(2'b01, 8'h07);
    a_l1 = 1'b0;
    idle(5);
    chk("R5 falling ignored irq", {7'd0, irq_a_n}, 8'h01);
    a_l1 = 1'b1;
    idle(5);
    chk("R7 irqA low", {6'd0, irq_a_n, irq_b_n}, 8'h01);
    rdx(2'b00, 8'h35, "R8 clear read");
    idle(2);
    chk("R7 irqA released", {7'd0, irq_a_n}, 8'h01);
    // R6 line 2 input on B
    wr(2'b11, 8'h1C);
    b_l2 = 1'b0;
    idle(5);
    chk("R6 falling ignored", {7'd0, irq_b_n}, 8'h01);
    b_l2 = 1'b1;
    idle(5);
    chk("R6 irqB low", {6'd0, irq_a_n, irq_b_n}, 8'h02);
    rdx(2'b11, 8'h5C, "R6 flag bit6");
    rdx(2'b10, 8'h5A, "R8 clear B");
    rdx(2'b11, 8'h1C, "R6 flag cleared");
    // R9 level output
    wr(2'b01, 8'h3C);
    idle(1);
    chk("R9 high", {6'd0, a_l2_oe, a_l2_o}, 8'h03);
    wr(2'b01, 8'h34);
    idle(1);
    chk("R9 low", {6'd0, a_l2_oe, a_l2_o}, 8'h02);
    // R10 pulse
    wr(2'b01, 8'h2C);
    idle(1);
    chk("R10 idle high", {7'd0, a_l2_o}, 8'h01);
    rdx(2'b00, 8'h35, "R10 read");
    chk("R10 low", {7'd0, a_l2_o}, 8'h00);
    idle(1);
    chk("R10 back high", {7'd0, a_l2_o}, 8'h01);
    // R11 handshake
    wr(2'b01, 8'h24);
    idle(1);
    rdx(2'b00, 8'h35, "R11 read");
    idle(4);
    chk("R11 held low", {7'd0, a_l2_o}, 8'h00);
    a_l1 = 1'b0;
    idle(5);
    chk("R11 released", {7'd0, a_l2_o}, 8'h01);
    a_l1 = 1'b1;
    wr(2'b01, 8'h04);
    idle(4);
    rdx(2'b00, 8'h35, "R8 pre-clear");
    rdx(2'b01, 8'h04, "R8 clean");
    // R8 edge coincides with clearing read
    a_l1 = 1'b0;
    idle(2);
    rdx(2'b00, 8'h35, "R8 collide read");
    rdx(2'b01, 8'h84, "R8 set wins");
    idle(3);
    chk("R12 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule